// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target device keeps pulled low after a transfer was cut short. When it accepts a recovery request, it holds the bus controller it serves in reset and releases both open-drain lines. It then reads the synchronised SCL and SDA levels back. While the bus is not free, it pulls SCL low for a fixed number of clock cycles, releases it, lets the lines settle and tests again. Each of these clocks lets a target that is part way through a byte shift out its remaining bits and let go of SDA.

The sequence ends in one of two ways: the bus reads free, or the pulse budget runs out. In both cases the block removes the controller reset, pulses a reinitialise strobe together with a done strobe, and leaves a success or fail flag standing. A bus that is already free when the request arrives gets no pulses at all. The pulse width is a cycle-count parameter; the default of 1250 cycles gives 10 us at a 125 MHz clock. Protocol transfers belong to the controller, not to this block.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, `ctrl_reset`, `ctrl_reinit`, `recover_done`, `recover_ok`, `recover_fail`, `scl_drive_low` and `sda_drive_low` are all 0, so both lines are released.
- R2: From the cycle after a request is accepted until the cycle before `recover_done`, `ctrl_reset` is 1. In the cycle where `recover_done` is 1, `ctrl_reset` is 0.
- R3: The block never pulls SDA low (`sda_drive_low` stays 0). SCL is released when a recovery starts, before the first bus test.
- R4: The bus counts as free only when SCL and SDA both read 1. A bus that is free at the first test gets zero SCL pulses and ends with `recover_ok`=1.
- R5: Each pulse holds `scl_drive_low`=1 for exactly PULSE_CYCLES cycles. SCL then stays released for at least SETTLE_CYCLES cycles before the next bus test or pulse.
- R6: Pulses stop as soon as a bus test finds the bus free. The pulse count equals the number of clocks a stuck target needs to release SDA, when that number is at most MAX_PULSES, and the result is `recover_ok`=1.
- R7: At most MAX_PULSES pulses are issued per recovery. If the bus is still not free after the last one, the result is `recover_ok`=0 and `recover_fail`=1. This also applies when SCL itself is held low.
- R8: `recover_done` and `ctrl_reinit` are high together for exactly one cycle, once per accepted request. At that moment exactly one of `recover_ok` and `recover_fail` is 1.
- R9: A request that arrives while a recovery is running is ignored: no second done strobe and no extra pulses.
- R10: `recover_ok` and `recover_fail` hold their values until the next accepted request, which clears both in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_req | input | 1 | Start a recovery; sampled only while idle |
| scl_in | input | 1 | SCL pad readback (asynchronous) |
| sda_in | input | 1 | SDA pad readback (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| ctrl_reset | output | 1 | Holds the bus controller in reset |
| ctrl_reinit | output | 1 | One-cycle strobe: reinitialise the controller |
| recover_done | output | 1 | One-cycle strobe: sequence finished |
| recover_ok | output | 1 | Last recovery ended with a free bus |
| recover_fail | output | 1 | Last recovery ran out of pulses |

## Verification
A wrong state or timer value shows at the SCL drive pin in the same cycle. Symptoms include a pulse that is one cycle short or long, a pulse that starts without a settle gap, or a pulse issued although the bus already reads free. A pulse counter that is off by one shows up as one pulse too many or too few in the longest stuck case, and is visible at the done strobe, a few cycles after the final pulse. A status or reset-release error is visible in the very cycle `recover_done` rises, because the result flags and `ctrl_reset` are compared there.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CHECK  = 3'd2,
    ST_PULSE  = 3'd3,
    ST_FINISH = 3'd4
  } rec_state_t;

  // Width able to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bus is idle only with both lines high
  function automatic logic lines_free(input logic scl, input logic sda);
    return scl & sda;
  endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2cr_timer.sv
module i2cr_timer #(
  parameter int unsigned WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             expired
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2cr_try_counter.sv
module i2cr_try_counter #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic incr,
  output logic at_limit
);
  import i2cr_pkg::*;
  localparam int unsigned CW = cnt_width(LIMIT);

  logic [CW-1:0] tries_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tries_q <= '0;
    else if (clear) tries_q <= '0;
    else if (incr)  tries_q <= tries_q + 1'b1;
  end

  assign at_limit = (tries_q == CW'(LIMIT));

  // R7: the pulse tally never passes the budget
  assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= CW'(LIMIT));
  // R7: no further pulse is requested once the budget is used
  assert_no_incr_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit |-> !incr);
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int unsigned PULSE_CYCLES  = 1250,
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned MAX_PULSES    = 100,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_drive_low,
  output logic sda_drive_low,
  output logic ctrl_reset,
  output logic ctrl_reinit,
  output logic recover_done,
  output logic recover_ok,
  output logic recover_fail
);
  import i2cr_pkg::*;

  // Settle must cover the synchroniser latency
  localparam int unsigned SETTLE_EFF = max_u(max_u(SETTLE_CYCLES, SYNC_STAGES + 1), 1);
  localparam int unsigned PULSE_EFF  = max_u(PULSE_CYCLES, 1);
  localparam int unsigned TW         = cnt_width(max_u(PULSE_EFF, SETTLE_EFF));

  rec_state_t state_q, state_d;
  logic scl_sync, sda_sync;
  logic bus_free;
  logic tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic at_limit;
  logic start_ev;      // request accepted
  logic chk_busy;      // test found a stuck bus
  logic go_pulse;      // stuck bus and budget left
  logic give_up;       // stuck bus and budget used
  logic chk_free;      // test found a free bus
  logic ok_q, fail_q;

  i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_sync));
  i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_sync));

  assign bus_free = lines_free(scl_sync, sda_sync);

  assign start_ev = (state_q == ST_IDLE) && recover_req;
  assign chk_free = (state_q == ST_CHECK) && bus_free;
  assign chk_busy = (state_q == ST_CHECK) && !bus_free;
  assign go_pulse = chk_busy && !at_limit;
  assign give_up  = chk_busy && at_limit;

  i2cr_try_counter #(.LIMIT(MAX_PULSES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clear(start_ev), .incr(go_pulse), .at_limit(at_limit));

  // Timer is reloaded on entry to each timed state
  assign tmr_load = start_ev || go_pulse || ((state_q == ST_PULSE) && tmr_expired);
  assign tmr_val  = go_pulse ? TW'(PULSE_EFF - 1) : TW'(SETTLE_EFF - 1);

  i2cr_timer #(.WIDTH(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (recover_req) state_d = ST_SETTLE;
      ST_SETTLE: if (tmr_expired) state_d = ST_CHECK;
      ST_CHECK: begin
        if (bus_free || at_limit) state_d = ST_FINISH;
        else                      state_d = ST_PULSE;
      end
      ST_PULSE:  if (tmr_expired) state_d = ST_SETTLE;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
    end else if (start_ev) begin
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
    end else if (chk_free) begin
      ok_q   <= 1'b1;
    end else if (give_up) begin
      fail_q <= 1'b1;
    end
  end

  assign scl_drive_low = (state_q == ST_PULSE);
  assign sda_drive_low = 1'b0;
  assign ctrl_reset    = (state_q == ST_SETTLE) || (state_q == ST_CHECK) ||
                         (state_q == ST_PULSE);
  assign ctrl_reinit   = (state_q == ST_FINISH);
  assign recover_done  = (state_q == ST_FINISH);
  assign recover_ok    = ok_q;
  assign recover_fail  = fail_q;

  // R4: every pulse is preceded by a test that saw a stuck bus
  assert_check_before_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> $past(chk_busy));
  // R2: the controller stays in reset while SCL is pulled
  assert_reset_during_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> ctrl_reset);
  // R2: reset is released exactly as done rises
  assert_done_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    recover_done |-> (!ctrl_reset && $past(ctrl_reset)));
  // R8: a done strobe carries exactly one result flag
  assert_done_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recover_done |-> (recover_ok != recover_fail));
  // R8: done never lasts two cycles
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recover_done |=> !recover_done);
  // R5: a pulse ends only when its timer ran out
  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> $past(tmr_expired));
endmodule

// File: tb/i2c_bus_unstick_bench.sv
module i2c_bus_unstick_bench;
  localparam int PULSE  = 8;
  localparam int SETTLE = 4;
  localparam int MAXP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_req = 1'b0;
  logic scl_in, sda_in;
  logic scl_drive_low, sda_drive_low, ctrl_reset, ctrl_reinit;
  logic recover_done, recover_ok, recover_fail;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // Bus model: target holds SDA until it has seen release_after clocks
  int  pulses_seen = 0;
  int  pulse_base  = 0;
  int  release_after = 0;
  logic scl_stuck = 1'b0;
  logic target_hold;

  assign target_hold = (pulses_seen - pulse_base) < release_after;
  assign scl_in = !(scl_drive_low | scl_stuck);
  assign sda_in = !(sda_drive_low | target_hold);

  always #4 clk = ~clk;  // 125 MHz

  i2c_bus_unstick #(
    .PULSE_CYCLES(PULSE), .SETTLE_CYCLES(SETTLE), .MAX_PULSES(MAXP), .SYNC_STAGES(2)
  ) u_i2c_bus_unstick (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .ctrl_reset(ctrl_reset), .ctrl_reinit(ctrl_reinit),
    .recover_done(recover_done), .recover_ok(recover_ok), .recover_fail(recover_fail));

  // Port monitor, sampled on the falling edge
  logic prev_scl = 1'b0;
  int run_len = 0;
  int gap_len = 1000;
  int bad_width = 0;
  int bad_gap = 0;
  int sda_pulled = 0;
  int done_total = 0;
  int bad_done = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (sda_drive_low) sda_pulled++;
      if (scl_drive_low && !prev_scl) begin
        pulses_seen++;
        if (gap_len < SETTLE) bad_gap++;
        run_len = 1;
      end else if (scl_drive_low) begin
        run_len++;
      end else if (prev_scl) begin
        if (run_len != PULSE) bad_width++;
        gap_len = 1;
      end else begin
        gap_len++;
      end
      if (recover_done) begin
        done_total++;
        if (!ctrl_reinit || ctrl_reset) bad_done++;
      end else if (ctrl_reinit) begin
        bad_done++;
      end
      prev_scl = scl_drive_low;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Issue one request, return the pulses seen and check the reset window
  task automatic run_recovery(input int rel, input logic sstuck, input bit busy_req,
                              output int npulses, output bit got_ok, output bit got_fail);
    int base;
    int waitc;
    bit reset_gap;
    @(negedge clk);
    release_after = rel;
    scl_stuck = sstuck;
    pulse_base = pulses_seen;
    base = pulses_seen;
    recover_req = 1'b1;
    @(negedge clk);
    recover_req = 1'b0;
    check(ctrl_reset == 1'b1, "R2 reset asserted after request", int'(ctrl_reset), 1);
    check(recover_ok == 1'b0 && recover_fail == 1'b0, "R10 status cleared on request",
          int'({recover_ok, recover_fail}), 0);
    reset_gap = 1'b0;
    waitc = 0;
    while (!recover_done && waitc < 5000) begin
      if (!ctrl_reset) reset_gap = 1'b1;
      if (busy_req && waitc == 20) recover_req = 1'b1;
      if (busy_req && waitc == 21) recover_req = 1'b0;
      @(negedge clk);
      waitc++;
    end
    recover_req = 1'b0;
    check(recover_done == 1'b1, "R8 done strobe seen", int'(recover_done), 1);
    check(!reset_gap, "R2 reset held until done", int'(reset_gap), 0);
    check(ctrl_reset == 1'b0 && ctrl_reinit == 1'b1, "R8 reinit with reset low at done",
          int'({ctrl_reset, ctrl_reinit}), 1);
    npulses = pulses_seen - base;
    got_ok = recover_ok;
    got_fail = recover_fail;
    @(negedge clk);
    check(recover_done == 1'b0, "R8 done lasts one cycle", int'(recover_done), 0);
  endtask

  task automatic t_reset_state;
    check({ctrl_reset, ctrl_reinit, recover_done, recover_ok, recover_fail,
           scl_drive_low, sda_drive_low} == 7'd0, "R1 reset state",
          int'({ctrl_reset, ctrl_reinit, recover_done, recover_ok, recover_fail,
                scl_drive_low, sda_drive_low}), 0);
  endtask

  task automatic t_free_bus;
    int np; bit ok; bit fl;
    run_recovery(0, 1'b0, 1'b0, np, ok, fl);
    check(np == 0, "R4 no pulses on a free bus", np, 0);
    check(ok && !fl, "R4 ok on a free bus", int'({ok, fl}), 2);
  endtask

  task automatic t_release_after(input int k);
    int np; bit ok; bit fl;
    run_recovery(k, 1'b0, 1'b0, np, ok, fl);
    check(np == k, "R6 pulse count matches target need", np, k);
    check(ok && !fl, "R6 ok after target releases", int'({ok, fl}), 2);
  endtask

  task automatic t_never_release;
    int np; bit ok; bit fl;
    run_recovery(1000, 1'b0, 1'b0, np, ok, fl);
    check(np == MAXP, "R7 pulse budget capped", np, MAXP);
    check(!ok && fl, "R7 fail when budget exhausted", int'({ok, fl}), 1);
    repeat (10) @(negedge clk);
    check(!recover_ok && recover_fail, "R10 fail status held", int'({recover_ok, recover_fail}), 1);
  endtask

  task automatic t_scl_stuck;
    int np; bit ok; bit fl;
    run_recovery(0, 1'b1, 1'b0, np, ok, fl);
    check(np == MAXP, "R7 SCL held low uses full budget", np, MAXP);
    check(!ok && fl, "R4 SCL low is not free", int'({ok, fl}), 1);
    scl_stuck = 1'b0;
  endtask

  task automatic t_busy_request;
    int np; bit ok; bit fl; int d0;
    d0 = done_total;
    run_recovery(1000, 1'b0, 1'b1, np, ok, fl);
    repeat (40) @(negedge clk);
    check(done_total - d0 == 1, "R9 request while busy ignored (done count)", done_total - d0, 1);
    check(np == MAXP, "R9 no extra pulses from busy request", np, MAXP);
    check(!ctrl_reset && !scl_drive_low, "R9 block idle afterwards",
          int'({ctrl_reset, scl_drive_low}), 0);
  endtask

  task automatic t_monitor_summary;
    check(bad_width == 0, "R5 every pulse exactly PULSE cycles", bad_width, 0);
    check(bad_gap == 0, "R5 settle gap before each pulse", bad_gap, 0);
    check(sda_pulled == 0, "R3 SDA never pulled low", sda_pulled, 0);
    check(bad_done == 0, "R8 done and reinit together with reset low", bad_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_free_bus();
    t_release_after(1);
    t_release_after(3);
    t_release_after(MAXP);
    t_never_release();
    t_free_bus();
    t_scl_stuck();
    t_busy_request();
    t_monitor_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles >= 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule